// File: doc/BRIEF.md
# Half-Duplex Collision Detect and Indication

This block sits at the controller side of an Ethernet PHY channel. It turns transmit-active and receive-active indications into the collision (COL) and carrier-sense (CRS) signals. A collision is reported only when the channel runs half duplex with the link up and diagnostic loopback off. At 10 Mb/s, an SQE test or a jabber event also reports a collision. During a 10 Mb/s collision the block tells the receive path to force its data nibble to zero.

A collision-test setting loops the transmit enable straight onto COL and asks the twisted-pair transmitter to go quiet. This happens whatever the duplex, link or loopback state is. The block also drives an active-low indicator output. When that output is selected as the collision indicator, it goes low for a fixed time (100 ms by default, counted in clock cycles) after each collision starts. A new collision during the pulse starts the full time again.

Top module: `hdx_col_top`

## Requirements
- R1: With full duplex low, link good high and diagnostic loopback low, `col_out` is high in the same cycle in which `tx_active` and `rx_active` are both high (collision test low).
- R2: With collision test low, `col_out` stays low whenever `full_duplex` is high, `link_good` is low or `diag_loopback` is high, whatever the activity and event inputs are.
- R3: With `speed_10` high and the gating of R1 satisfied, a high `sqe_test` or `jabber_det` raises `col_out` even without receive activity. With `speed_10` low these inputs have no effect.
- R4: `crs_out` is high when `rx_active` is high, when `tx_active` is high in half duplex, or during a collision. Once a collision has been seen, `crs_out` stays high in every later cycle in which `tx_active` or `rx_active` is still high, even if the gating condition drops. It falls in the first cycle in which both are low.
- R5: `rxd_force_zero` is high exactly when `speed_10` is high and a gated collision (R1 or R3) is present in that cycle.
- R6: With `col_test` high, `col_out` equals `tx_active` in the same cycle regardless of duplex, link and loopback, and `tp_tx_disable` is high. With `col_test` low, `tp_tx_disable` is low.
- R7: Each rising edge of `col_out` makes the indicator pulse start on the next cycle. The pulse lasts exactly LED_TICKS cycles (CLK_HZ/1000 × PULSE_MS). A rising edge during a pulse restarts the count in full.
- R8: `led_col_n` is high whenever `led_sel_col` is low, and it is low whenever `led_sel_col` is high during a pulse.
- R9: While `rst_n` is low, `col_out`, `rxd_force_zero` and `tp_tx_disable` follow only their inputs, the collision hold is cleared and `led_col_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_active | input | 1 | Transmit enable from the controller |
| rx_active | input | 1 | Non-idle receive activity detected |
| full_duplex | input | 1 | 1 = full-duplex mode |
| link_good | input | 1 | 1 = link pass, 0 = link fail |
| diag_loopback | input | 1 | Diagnostic loopback enabled |
| speed_10 | input | 1 | 1 = 10 Mb/s, 0 = 100 Mb/s |
| col_test | input | 1 | Collision-test setting |
| sqe_test | input | 1 | SQE test in progress (10 Mb/s) |
| jabber_det | input | 1 | Jabber condition detected (10 Mb/s) |
| led_sel_col | input | 1 | Indicator pin selected as collision output |
| col_out | output | 1 | Collision to the controller |
| crs_out | output | 1 | Carrier sense to the controller |
| rxd_force_zero | output | 1 | Force 10 Mb/s receive nibble to zero |
| tp_tx_disable | output | 1 | Disable twisted-pair transmit (test mode) |
| led_col_n | output | 1 | Stretched collision indicator, active low |

## Verification
On every cycle the assertions check these relations: collision under half-duplex gating, silence under full duplex, link fail or loopback, the test-loop override, forcing of the receive nibble, CRS holding while traffic lasts after a collision, and the indicator going low the cycle after a collision starts. Some behaviours depend on history, and only the bench's reference model can show them. These are the exact pulse length, the restart when a collision arrives during a pulse, the ending of the hold once both directions go quiet, and 10 Mb/s events having no effect at 100 Mb/s.

// File: rtl/hdx_col_pkg.sv
// Package: shared mode type and gating helper for the collision unit.
// Assumes all mode bits are static or synchronous to clk.
package hdx_col_pkg;

    typedef struct packed {
        logic full_duplex;
        logic link_good;
        logic diag_loopback;
        logic speed_10;
    } hdx_mode_t;

    // Collision function is permitted only in half duplex, link up, no loopback.
    function automatic logic col_permitted(input hdx_mode_t m);
        return !m.full_duplex && m.link_good && !m.diag_loopback;
    endfunction

    // Number of clock cycles in the indicator pulse.
    function automatic int unsigned pulse_ticks(input int unsigned clk_hz,
                                                input int unsigned pulse_ms);
        return (clk_hz / 1000) * pulse_ms;
    endfunction

endpackage

// File: rtl/hdx_col_detect.sv
// Module: hdx_col_detect
// Decides whether a gated collision is present and remembers it until both
// traffic directions are idle. Assumes synchronous inputs; reset is
// synchronous and active low.
module hdx_col_detect
    import hdx_col_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hdx_mode_t mode,
    input  logic      tx_active,
    input  logic      rx_active,
    input  logic      sqe_test,
    input  logic      jabber_det,
    output logic      col_now,
    output logic      col_held
);

    logic permitted;
    logic overlap;
    logic event_10;
    logic any_traffic;
    logic hold_q;

    // Combine gating, traffic overlap and 10 Mb/s events.
    always_comb begin
        permitted   = col_permitted(mode);
        overlap     = tx_active && rx_active;
        event_10    = mode.speed_10 && (sqe_test || jabber_det);
        any_traffic = tx_active || rx_active;
        col_now     = permitted && (overlap || event_10);
        col_held    = hold_q && any_traffic;
    end

    // Keep the collision memory alive while either direction is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= (col_now || hold_q) && any_traffic;
        end
    end

endmodule

// File: rtl/hdx_col_led_stretch.sv
// Module: hdx_col_led_stretch
// Stretches each rising edge of the collision signal into a fixed-length
// active-low indicator pulse; a new edge restarts the count.
// Assumes TICKS >= 1.
module hdx_col_led_stretch #(
    parameter int unsigned TICKS = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_in,
    input  logic enable,
    output logic led_n
);

    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);

    logic [CW-1:0] cnt_q;
    logic          col_prev_q;
    logic          start;

    // Detect the start of a collision.
    always_comb start = col_in && !col_prev_q;

    // Load on a start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            col_prev_q <= 1'b0;
        end else begin
            col_prev_q <= col_in;
            if (start) begin
                cnt_q <= LOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Drive the pin low only when selected and a pulse is running.
    always_comb led_n = !(enable && (cnt_q != '0));

endmodule

// File: rtl/hdx_col_top.sv
// Module: hdx_col_top
// Collision detect and indication for one PHY channel: COL, CRS, the
// receive-nibble force, the test-mode transmit disable and the stretched
// indicator. Assumes synchronous inputs and an active-low synchronous reset.
module hdx_col_top
    import hdx_col_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 25000000,
    parameter int unsigned PULSE_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic rx_active,
    input  logic full_duplex,
    input  logic link_good,
    input  logic diag_loopback,
    input  logic speed_10,
    input  logic col_test,
    input  logic sqe_test,
    input  logic jabber_det,
    input  logic led_sel_col,
    output logic col_out,
    output logic crs_out,
    output logic rxd_force_zero,
    output logic tp_tx_disable,
    output logic led_col_n
);

    localparam int unsigned LED_TICKS = pulse_ticks(CLK_HZ, PULSE_MS);

    hdx_mode_t mode;
    logic      col_now;
    logic      col_held;
    logic      tx_echo;

    // Bundle the mode inputs.
    always_comb begin
        mode.full_duplex   = full_duplex;
        mode.link_good     = link_good;
        mode.diag_loopback = diag_loopback;
        mode.speed_10      = speed_10;
    end

    hdx_col_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .tx_active  (tx_active),
        .rx_active  (rx_active),
        .sqe_test   (sqe_test),
        .jabber_det (jabber_det),
        .col_now    (col_now),
        .col_held   (col_held)
    );

    // Form the controller-side outputs; the test loop overrides gating.
    always_comb begin
        tx_echo        = tx_active && !full_duplex && !(col_now || col_held);
        col_out        = col_test ? tx_active : col_now;
        crs_out        = rx_active || tx_echo || col_now || col_held;
        rxd_force_zero = speed_10 && col_now;
        tp_tx_disable  = col_test;
    end

    hdx_col_led_stretch #(
        .TICKS (LED_TICKS)
    ) u_led (
        .clk    (clk),
        .rst_n  (rst_n),
        .col_in (col_out),
        .enable (led_sel_col),
        .led_n  (led_col_n)
    );

endmodule

// File: rtl/hdx_col_checker.sv
// Module: hdx_col_checker
// Property checks on the ports of hdx_col_top, attached by bind.
module hdx_col_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic rx_active,
    input logic full_duplex,
    input logic link_good,
    input logic diag_loopback,
    input logic speed_10,
    input logic col_test,
    input logic sqe_test,
    input logic jabber_det,
    input logic led_sel_col,
    input logic col_out,
    input logic crs_out,
    input logic rxd_force_zero,
    input logic tp_tx_disable,
    input logic led_col_n
);

    assert_overlap_collides_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_test && tx_active && rx_active && !full_duplex && link_good && !diag_loopback)
        |-> col_out);

    assert_gated_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_test && (full_duplex || !link_good || diag_loopback)) |-> !col_out);

    assert_crs_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_out && !col_test) |=> (crs_out || (!tx_active && !rx_active)));

    assert_nibble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_10 && col_out && !col_test) |-> rxd_force_zero);

    assert_test_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_test |-> (col_out == tx_active) && tp_tx_disable);

    assert_pulse_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_out) |=> (!led_sel_col || !led_col_n));

    assert_led_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !led_sel_col |-> led_col_n);

endmodule

bind hdx_col_top hdx_col_checker u_hdx_col_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_active      (tx_active),
    .rx_active      (rx_active),
    .full_duplex    (full_duplex),
    .link_good      (link_good),
    .diag_loopback  (diag_loopback),
    .speed_10       (speed_10),
    .col_test       (col_test),
    .sqe_test       (sqe_test),
    .jabber_det     (jabber_det),
    .led_sel_col    (led_sel_col),
    .col_out        (col_out),
    .crs_out        (crs_out),
    .rxd_force_zero (rxd_force_zero),
    .tp_tx_disable  (tp_tx_disable),
    .led_col_n      (led_col_n)
);

// File: tb/test_hdx_col_top.sv
module test_hdx_col_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  TB_CLK_HZ  = 10000;
    localparam int  TB_MS      = 2;
    localparam int  TICKS      = (TB_CLK_HZ / 1000) * TB_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx = 0, rx = 0, fdx = 0, link = 1, lb = 0, s10 = 0;
    logic ct = 0, sqe = 0, jab = 0, sel = 1;
    logic col_out, crs_out, rxd_force_zero, tp_tx_disable, led_col_n;

    int checks = 0;
    int fails = 0;
    string tag = "R9";
    bit done = 0;

    // Reference model state
    int  m_hold = 0;
    int  m_cnt = 0;
    int  m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdx_col_top #(.CLK_HZ(TB_CLK_HZ), .PULSE_MS(TB_MS)) i_hdx_col_top (
        .clk(clk), .rst_n(rst_n), .tx_active(tx), .rx_active(rx),
        .full_duplex(fdx), .link_good(link), .diag_loopback(lb),
        .speed_10(s10), .col_test(ct), .sqe_test(sqe), .jabber_det(jab),
        .led_sel_col(sel), .col_out(col_out), .crs_out(crs_out),
        .rxd_force_zero(rxd_force_zero), .tp_tx_disable(tp_tx_disable),
        .led_col_n(led_col_n)
    );

    function automatic bit f_raw();
        return (!fdx && link && !lb) && ((tx && rx) || (s10 && (sqe || jab)));
    endfunction
    function automatic bit f_col();
        return ct ? tx : f_raw();
    endfunction
    function automatic bit f_held();
        return (m_hold != 0) && (tx || rx);
    endfunction

    // Model state advance on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 0; m_cnt = 0; m_prev = 0;
        end else begin
            bit c;
            c = f_col();
            m_hold = ((f_raw() || f_held()) && (tx || rx)) ? 1 : 0;
            if (c && m_prev == 0) m_cnt = TICKS;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_prev = c ? 1 : 0;
        end
    end

    task automatic chk(string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model away from the clock edge
    always @(negedge clk) begin
        if (!done) begin
            chk("col_out", col_out, f_col());
            chk("crs_out", crs_out, rx || (tx && !fdx) || f_raw() || f_held());
            chk("rxd_force_zero", rxd_force_zero, s10 && f_raw());
            chk("tp_tx_disable", tp_tx_disable, ct);
            chk("led_col_n", led_col_n, !(sel && m_cnt > 0));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: reset state
        tag = "R9"; cyc(3);
        rst_n = 1; cyc(2);

        // R1: half-duplex overlap in several patterns
        tag = "R1";
        tx = 1; cyc(3); rx = 1; cyc(4); rx = 0; cyc(2); tx = 0; cyc(2);
        rx = 1; cyc(2); tx = 1; cyc(3); tx = 0; rx = 0; cyc(TICKS + 3);

        // R2: gating by full duplex, link fail and loopback
        tag = "R2";
        fdx = 1; tx = 1; rx = 1; cyc(4); tx = 0; rx = 0; fdx = 0; cyc(2);
        link = 0; tx = 1; rx = 1; cyc(4); tx = 0; rx = 0; link = 1; cyc(2);
        lb = 1; tx = 1; rx = 1; s10 = 1; jab = 1; cyc(4);
        tx = 0; rx = 0; lb = 0; s10 = 0; jab = 0; cyc(2);

        // R3: 10 Mb/s SQE and jabber; ignored at 100 Mb/s
        tag = "R3";
        s10 = 1; sqe = 1; cyc(3); sqe = 0; cyc(2); jab = 1; cyc(3); jab = 0; cyc(2);
        s10 = 0; sqe = 1; cyc(3); sqe = 0; jab = 1; cyc(3); jab = 0; cyc(TICKS + 2);

        // R4: CRS hold through tail of traffic and a gating drop
        tag = "R4";
        tx = 1; rx = 1; cyc(2); rx = 0; cyc(3); tx = 0; cyc(2);
        tx = 1; rx = 1; cyc(2); link = 0; fdx = 1; rx = 0; cyc(3);
        tx = 0; rx = 1; cyc(2); rx = 0; cyc(2); link = 1; fdx = 0; cyc(2);
        fdx = 1; tx = 1; cyc(3); tx = 0; fdx = 0; cyc(TICKS + 2);

        // R5: receive nibble force at 10 Mb/s only
        tag = "R5";
        s10 = 1; tx = 1; rx = 1; cyc(3); s10 = 0; cyc(3); tx = 0; rx = 0; cyc(TICKS + 2);

        // R6: collision-test loop overrides gating
        tag = "R6";
        ct = 1; fdx = 1; link = 0; lb = 1;
        tx = 1; cyc(2); tx = 0; cyc(2); rx = 1; cyc(2); tx = 1; cyc(2);
        tx = 0; rx = 0; ct = 0; fdx = 0; link = 1; lb = 0; cyc(TICKS + 2);

        // R7: pulse length and restart
        tag = "R7";
        tx = 1; rx = 1; cyc(1); rx = 0; cyc(TICKS / 2);
        rx = 1; cyc(1); rx = 0; tx = 0; cyc(TICKS + 4);
        tx = 1; rx = 1; cyc(TICKS + 5); tx = 0; rx = 0; cyc(TICKS + 2);

        // R8: unselected indicator stays high, reselect mid-pulse
        tag = "R8";
        sel = 0; tx = 1; rx = 1; cyc(2); tx = 0; rx = 0; cyc(3);
        sel = 1; cyc(3); sel = 0; cyc(TICKS); sel = 1; cyc(2);

        // R9: reset in the middle of a pulse and a hold
        tag = "R9";
        tx = 1; rx = 1; cyc(3); rst_n = 0; cyc(3); tx = 0; rx = 0; cyc(2);
        rst_n = 1; cyc(3);

        finish_run();
    end

endmodule